// File: doc/BRIEF.md
# SPI Register Target with Selectable Wire Mode

This block is the serial front end of a register space. An external host opens a frame by pulling chip select low and clocks in a command byte: a direction bit followed by a seven-bit register address. The data bytes follow, and every further eight clocks moves one more byte of a burst. Writes leave the block as single-cycle strobes on a parallel register bus. Reads fetch a byte from that bus and shift it back to the host. All pins pass through synchronizers, so the register bus and all frame state run on the system clock.

Read data can leave on a dedicated output pin (4-wire) or on the data-in line itself, which the block takes over after the command byte (3-wire). A small configuration register inside the block is reached through the same frames. It selects the wire mode and enables or disables the address stepping between burst bytes. The pad ring turns each output/enable pair into a tri-state driver. The block expects the serial clock to idle high and each half period to last at least four system clocks.

Top module: `spi_reg_target`

## Requirements
- R1: A frame begins when csb_i is low, and its first bit is the one taken on the first falling spc_i edge after that. Raising csb_i ends the frame and returns the block to the command phase.
- R2: The first bit of a frame is the direction (1 = read, 0 = write). The next seven bits are the register address, MSB first. Data bytes follow, MSB first.
- R3: Each further group of eight clocks in the same frame moves one more data byte of a burst.
- R4: Input is sampled on falling spc_i edges. The read data bit changes only after rising spc_i edges.
- R5: Each completed write data byte gives exactly one one-cycle reg_we_o pulse, with reg_addr_o and reg_wdata_o valid in that cycle. reg_we_o and reg_re_o are never high together.
- R6: On a read, the block drives data starting at bit 8. A one-cycle reg_re_o pulse fetches each byte, and reg_rdata_i is sampled in the cycle of that pulse. In 4-wire mode the data appears on sdo_o with sdo_oe_o high. In 3-wire mode it appears on sdio_o with sdio_oe_o high, which drives the data-in line. Writes behave the same in both modes.
- R7: Both output enables are low while csb_i is high and during the command byte, and they are never high together.
- R8: Address stepping is on after reset. The address then steps by one after each data byte and wraps from 0x7F to 0x00.
- R9: With stepping off, every byte of a burst uses the address given in the command byte.
- R10: A configuration register sits at address 0x05 and resets to 0x02. Bit 0 = 1 selects 3-wire mode. Bit 1 = 1 enables address stepping. The other bits read as 0. Accesses to this address stay inside the block and give no reg_we_o or reg_re_o pulse.
- R11: If csb_i rises before a data byte is complete, that partial byte is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csb_i | input | 1 | Chip select, active low |
| spc_i | input | 1 | Serial clock, idles high |
| sdi_i | input | 1 | Data-in line, shared with read data in 3-wire mode |
| sdo_o | output | 1 | 4-wire read data |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| sdio_o | output | 1 | 3-wire read data for the shared line |
| sdio_oe_o | output | 1 | Drive enable for the shared line |
| reg_addr_o | output | 7 | Register bus address |
| reg_wdata_o | output | 8 | Register bus write data |
| reg_we_o | output | 1 | Register bus write strobe |
| reg_re_o | output | 1 | Register bus read strobe |
| reg_rdata_i | input | 8 | Register bus read data, valid in the reg_re_o cycle |

## Verification
The assertions take two things for granted. First, spc_i half periods are long enough that a rising edge never lands in the cycle just after a falling edge, since the read fetch uses that cycle. Second, csb_i changes only while spc_i is high. The stimulus uses half periods of eight system clocks. It moves chip select only with the serial clock parked high, and it changes the master's data together with the rising edge, so each sampled bit is stable for a full half period. The bench register model answers reg_rdata_i combinationally from reg_addr_o, so the read-strobe assumption holds.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_e;

  typedef struct packed {
    logic auto_inc;
    logic three_wire;
  } cfg_t;
endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[g]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_reg_cfg.sv
module spi_reg_cfg
  import spi_reg_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] CFG_RESET = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        wdata_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] rdata_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= cfg_t'(CFG_RESET[1:0]);
    else if (we_i) cfg_q <= cfg_t'(wdata_i);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{(DATA_W-2){1'b0}}, cfg_q.auto_inc, cfg_q.three_wire};
endmodule

// File: rtl/spi_reg_frame.sv
module spi_reg_frame
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 1,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 7'h05
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csb_s_i,
  input  logic              spc_s_i,
  input  logic              sdi_s_i,
  input  logic              auto_inc_i,
  output logic              rise_o,
  output phase_e            phase_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  output logic              cfg_we_o,
  output logic              cfg_rd_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              spc_q;
  logic              fall;
  phase_e            phase_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-2:0] sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] next_addr;
  logic [DATA_W-1:0] byte_w;

  assign fall      = spc_q & ~spc_s_i;
  assign rise_o    = ~spc_q & spc_s_i;
  assign byte_w    = {sh_q, sdi_s_i};
  assign step      = {{(ADDR_W-1){1'b0}}, auto_inc_i};
  assign next_addr = addr_q + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) spc_q <= 1'b1;
    else         spc_q <= spc_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_CMD;
      bit_cnt_q   <= '0;
      sh_q        <= '0;
      addr_q      <= '0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      bus_we_o    <= 1'b0;
      bus_re_o    <= 1'b0;
      cfg_we_o    <= 1'b0;
      cfg_rd_o    <= 1'b0;
    end else begin
      bus_we_o <= 1'b0;
      bus_re_o <= 1'b0;
      cfg_we_o <= 1'b0;
      cfg_rd_o <= 1'b0;
      if (csb_s_i) begin
        phase_q   <= PH_CMD;
        bit_cnt_q <= '0;
      end else if (fall) begin
        sh_q      <= byte_w[DATA_W-2:0];
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == LAST_BIT) begin
          unique case (phase_q)
            PH_CMD: begin
              addr_q <= byte_w[ADDR_W-1:0];
              if (byte_w[DATA_W-1]) begin
                phase_q    <= PH_RD;
                bus_addr_o <= byte_w[ADDR_W-1:0];
                if (byte_w[ADDR_W-1:0] == CFG_ADDR) cfg_rd_o <= 1'b1;
                else                                bus_re_o <= 1'b1;
              end else begin
                phase_q <= PH_WR;
              end
            end
            PH_WR: begin
              bus_addr_o  <= addr_q;
              bus_wdata_o <= byte_w;
              addr_q      <= next_addr;
              if (addr_q == CFG_ADDR) cfg_we_o <= 1'b1;
              else                    bus_we_o <= 1'b1;
            end
            PH_RD: begin
              // prefetch the byte the next eight clocks will carry
              addr_q     <= next_addr;
              bus_addr_o <= next_addr;
              if (next_addr == CFG_ADDR) cfg_rd_o <= 1'b1;
              else                       bus_re_o <= 1'b1;
            end
            default: phase_q <= PH_CMD;
          endcase
        end
      end
    end
  end

  assign phase_o = phase_q;

  a_r5_we_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |=> !bus_we_o);
  a_r6_re_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_o |=> !bus_re_o);
  a_r5_we_re_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));
  a_r10_cfg_not_on_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o || bus_re_o) |-> (bus_addr_o != CFG_ADDR));
  a_r11_we_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> (!$past(csb_s_i) && $past(fall)));
endmodule

// File: rtl/spi_reg_tx.sv
module spi_reg_tx
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csb_s_i,
  input  logic              rise_i,
  input  phase_e            phase_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              three_wire_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              sdio_o,
  output logic              sdio_oe_o
);
  logic [DATA_W-1:0] out_sr_q;
  logic              tx_q;
  logic              drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_sr_q <= '0;
      tx_q     <= 1'b0;
      drv_q    <= 1'b0;
    end else begin
      if (load_i) begin
        out_sr_q <= load_data_i;
      end else if (rise_i && !csb_s_i && phase_i == PH_RD) begin
        tx_q     <= out_sr_q[DATA_W-1];
        out_sr_q <= {out_sr_q[DATA_W-2:0], 1'b0};
        drv_q    <= 1'b1;
      end
      if (csb_s_i) drv_q <= 1'b0;
    end
  end

  assign sdo_o     = tx_q;
  assign sdio_o    = tx_q;
  assign sdo_oe_o  = drv_q & ~three_wire_i;
  assign sdio_oe_o = drv_q & three_wire_i;

  a_r7_single_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdo_oe_o && sdio_oe_o));
  a_r7_quiet_outside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o || sdio_oe_o) |-> !$past(csb_s_i));
  a_r7_quiet_in_command: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o || sdio_oe_o) |-> (phase_i == PH_RD));
  a_r4_launch_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_q) |-> $past(rise_i));
endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
  import spi_reg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-2:0] CFG_ADDR  = 7'h05,
  parameter logic [DATA_W-1:0] CFG_RESET = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csb_i,
  input  logic              spc_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic [DATA_W-2:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int ADDR_W = DATA_W - 1;

  logic [2:0]        pins_s;
  logic              rise;
  phase_e            phase;
  logic              cfg_we;
  logic              cfg_rd;
  cfg_t              cfg;
  logic [DATA_W-1:0] cfg_rdata;
  logic [DATA_W-1:0] load_data;

  // bit 2 csb, bit 1 spc, bit 0 sdi
  spi_reg_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({csb_i, spc_i, sdi_i}),
    .q_o   (pins_s)
  );

  spi_reg_frame #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .CFG_ADDR(CFG_ADDR)
  ) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .csb_s_i    (pins_s[2]),
    .spc_s_i    (pins_s[1]),
    .sdi_s_i    (pins_s[0]),
    .auto_inc_i (cfg.auto_inc),
    .rise_o     (rise),
    .phase_o    (phase),
    .bus_addr_o (reg_addr_o),
    .bus_wdata_o(reg_wdata_o),
    .bus_we_o   (reg_we_o),
    .bus_re_o   (reg_re_o),
    .cfg_we_o   (cfg_we),
    .cfg_rd_o   (cfg_rd)
  );

  spi_reg_cfg #(
    .DATA_W   (DATA_W),
    .CFG_RESET(CFG_RESET)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we),
    .wdata_i(reg_wdata_o[1:0]),
    .cfg_o  (cfg),
    .rdata_o(cfg_rdata)
  );

  assign load_data = cfg_rd ? cfg_rdata : reg_rdata_i;

  spi_reg_tx #(
    .DATA_W(DATA_W)
  ) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csb_s_i     (pins_s[2]),
    .rise_i      (rise),
    .phase_i     (phase),
    .load_i      (reg_re_o | cfg_rd),
    .load_data_i (load_data),
    .three_wire_i(cfg.three_wire),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .sdio_o      (sdio_o),
    .sdio_oe_o   (sdio_oe_o)
  );
endmodule

// File: tb/spi_reg_target_test.sv
module spi_reg_target_test;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       csb, spc, m_sdi;
  logic       sdo, sdo_oe, sdio, sdio_oe;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_we, reg_re;
  wire        sdi_line;

  logic [7:0] mem [0:127];
  int checks = 0, failures = 0, we_cnt = 0;
  logic tw = 1'b0;
  logic in_cmd = 1'b0, cmd_oe_seen, sdo_seen, sdio_seen;
  logic done = 1'b0;

  always #10 clk = ~clk;

  assign sdi_line  = sdio_oe ? sdio : m_sdi;
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (reg_we) begin
    mem[reg_addr] <= reg_wdata;
    we_cnt <= we_cnt + 1;
  end

  spi_reg_target uut (
    .clk_i(clk), .rst_ni(rst_n), .csb_i(csb), .spc_i(spc), .sdi_i(sdi_line),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sdio_o(sdio), .sdio_oe_o(sdio_oe),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we),
    .reg_re_o(reg_re), .reg_rdata_i(reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic rb);
    m_sdi = b;
    repeat (H) @(negedge clk);
    rb = tw ? sdi_line : sdo;
    if (in_cmd && (sdo_oe || sdio_oe)) cmd_oe_seen = 1'b1;
    if (sdo_oe) sdo_seen = 1'b1;
    if (sdio_oe) sdio_seen = 1'b1;
    spc = 1'b0;
    repeat (H) @(negedge clk);
    spc = 1'b1;
  endtask

  task automatic xfer(input logic [7:0] tb, input int nbits, output logic [7:0] rx);
    logic r;
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_bit(tb[i], r);
      rx[i] = r;
    end
  endtask

  task automatic begin_frame();
    cmd_oe_seen = 1'b0; sdo_seen = 1'b0; sdio_seen = 1'b0;
    @(negedge clk);
    csb = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic end_frame();
    repeat (H) @(negedge clk);
    csb = 1'b1;
    repeat (4 * H) @(negedge clk);
  endtask

  // bytes packed MSB-first: byte k at [31-8k -: 8]
  task automatic write_burst(input logic [6:0] a, input int n, input logic [31:0] d);
    logic [7:0] rx;
    begin_frame();
    in_cmd = 1'b1; xfer({1'b0, a}, 8, rx); in_cmd = 1'b0;
    for (int k = 0; k < n; k++) xfer(d[31-8*k -: 8], 8, rx);
    end_frame();
  endtask

  task automatic read_burst(input logic [6:0] a, input int n, output logic [31:0] q);
    logic [7:0] rx;
    q = '0;
    begin_frame();
    in_cmd = 1'b1; xfer({1'b1, a}, 8, rx); in_cmd = 1'b0;
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, rx);
      q[31-8*k -: 8] = rx;
    end
    end_frame();
  endtask

  task automatic t_reset();
    check("R7 sdo_oe after reset", sdo_oe, 0);
    check("R7 sdio_oe after reset", sdio_oe, 0);
    check("R5 we after reset", reg_we, 0);
    check("R6 re after reset", reg_re, 0);
  endtask

  task automatic t_cfg_default();
    logic [31:0] q;
    int w0 = we_cnt;
    read_burst(7'h05, 1, q);
    check("R10 cfg reset value", q[31:24], 8'h02);
    check("R10 no bus write on cfg read", we_cnt - w0, 0);
  endtask

  task automatic t_single();
    logic [31:0] q;
    int w0 = we_cnt;
    write_burst(7'h10, 1, 32'hA5000000);
    check("R2 single write data", mem[7'h10], 8'hA5);
    check("R5 one strobe per byte", we_cnt - w0, 1);
    read_burst(7'h10, 1, q);
    check("R4 R6 single read 4-wire", q[31:24], 8'hA5);
    check("R7 no drive in command byte", cmd_oe_seen, 0);
    check("R6 4-wire uses sdo", {sdo_seen, sdio_seen}, 2'b10);
  endtask

  task automatic t_burst();
    logic [31:0] q;
    int w0 = we_cnt;
    write_burst(7'h20, 3, 32'h11223300);
    check("R3 burst write strobes", we_cnt - w0, 3);
    check("R8 burst byte 0", mem[7'h20], 8'h11);
    check("R8 burst byte 1", mem[7'h21], 8'h22);
    check("R8 burst byte 2", mem[7'h22], 8'h33);
    read_burst(7'h20, 3, q);
    check("R3 R8 burst read", q[31:8], 24'h112233);
    write_burst(7'h7F, 2, 32'hDEAD0000);
    check("R8 wrap top", mem[7'h7F], 8'hDE);
    check("R8 wrap to zero", mem[7'h00], 8'hAD);
  endtask

  task automatic t_no_inc();
    logic [31:0] q;
    logic [7:0] keep;
    int w0 = we_cnt;
    keep = mem[7'h31];
    write_burst(7'h05, 1, 32'h00000000);
    check("R10 cfg write stays local", we_cnt - w0, 0);
    read_burst(7'h05, 1, q);
    check("R10 cfg readback", q[31:24], 8'h00);
    write_burst(7'h30, 2, 32'h44550000);
    check("R9 same address last byte", mem[7'h30], 8'h55);
    check("R9 next address untouched", mem[7'h31], keep);
    read_burst(7'h30, 2, q);
    check("R9 repeated read", q[31:16], 16'h5555);
  endtask

  task automatic t_three_wire();
    logic [31:0] q;
    write_burst(7'h05, 1, 32'h03000000);
    tw = 1'b1;
    read_burst(7'h20, 2, q);
    check("R6 3-wire read data", q[31:16], 16'h1122);
    check("R6 3-wire uses shared line", {sdo_seen, sdio_seen}, 2'b01);
    check("R7 3-wire command quiet", cmd_oe_seen, 0);
    write_burst(7'h40, 1, 32'h77000000);
    check("R6 3-wire write", mem[7'h40], 8'h77);
    check("R7 idle after frame", {sdo_oe, sdio_oe}, 2'b00);
    write_burst(7'h05, 1, 32'h02000000);
    tw = 1'b0;
  endtask

  task automatic t_partial();
    logic [7:0] rx;
    logic [7:0] keep;
    int w0 = we_cnt;
    keep = mem[7'h50];
    begin_frame();
    in_cmd = 1'b1; xfer(8'h50, 8, rx); in_cmd = 1'b0;
    xfer(8'hC3, 5, rx);
    end_frame();
    check("R11 partial byte no strobe", we_cnt - w0, 0);
    check("R11 partial byte no change", mem[7'h50], keep);
    write_burst(7'h50, 1, 32'h9A000000);
    check("R1 new frame after abort", mem[7'h50], 8'h9A);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'h3C;
    rst_n = 1'b0; csb = 1'b1; spc = 1'b1; m_sdi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_cfg_default();
    t_single();
    t_burst();
    t_no_inc();
    t_three_wire();
    t_partial();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule